// File: doc/BRIEF.md
# Password-Guarded Watchdog Timer

This block is a watchdog timer placed on a simple register bus. The bus has an address, write data, a write strobe and combinational read data. Software starts the watchdog and keeps it alive by rewriting its control register. The control register cannot be changed by a single stray store. A write only takes effect if it carries a second key byte and follows, directly, a write that carried a first key byte.

Once running, a selectable prescaler produces decrement ticks for a 16-bit down-counter. The counter is loaded from the reload field of the control register. On the way down, the block emits a one-cycle early-warning interrupt when the count reaches a programmable fraction of the full range. At zero it raises a reset request, which it holds until the block itself is reset. A reset-cause flag records the expiry. It survives the warm reset and is cleared only by the power-on reset, so boot code can tell why the system restarted.

Register map, by byte offset:
- 0x0: control.
- 0x4: reset cause.
- 0x8: status.

Top module: `guarded_wdog`

## Requirements
- R1: After power-on reset, all of the following read 0 and are low: control (offset 0x0), status (offset 0x8), reset cause (offset 0x4), `prewarn_irq` and `wdog_rst_req`.
- R2: A control write (offset 0x0) updates the configuration only if both of these hold:
  - its bits 23:16 equal 0xDC;
  - the immediately preceding control write carried 0xBE in bits 23:16.
  A lone 0xDC write changes nothing.
- R3: Any control write whose key byte is not the one expected next returns the sequencer to idle and leaves the configuration unchanged. This includes 0xBE twice in a row and an unrelated byte between the two keys.
- R4: A committed write with bit 31 set does three things:
  - it loads the counter with bits 15:0;
  - it makes status bit 31 read 1;
  - it makes status bits 15:0 read the current count, which only decreases while running.
- R5: Control bits 25:24 select the cycles per decrement: encoding 0 gives DIV0, 1 gives DIV1, 2 gives DIV2 and 3 gives DIV3. The defaults are 1, 64, 4096 and 0x40000.
- R6: A committed write with bit 31 set while running reloads the counter and restarts the prescaler (keep-alive).
- R7: A committed write with bit 31 clear stops the watchdog. Status bit 31 reads 0, the count freezes, and no reset request is raised.
- R8: Control bits 27:26 (value e) set the early-warning threshold to 0xFFFF >> (e+1); e=3 gives 1/16 of the range. `prewarn_irq` is high for exactly the one cycle after the decrement that makes the count equal to the threshold.
- R9: When status reads a count of 0 while running, `wdog_rst_req` rises on the next clock edge and stays high until `rst` or `por_rst`.
- R10: Reset-cause bit 31 (offset 0x4) becomes 1 one cycle after `wdog_rst_req` rises. It survives `rst` and is cleared only by `por_rst`.
- R11: Control reads back as follows:
  - bit 31 is the enable;
  - bits 27:26 are the early-warning setting;
  - bits 25:24 are the divider select;
  - bits 15:0 are the reload value;
  - the key field (bits 23:16) and every other bit read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high warm reset; keeps the reset-cause flag |
| por_rst | input | 1 | Synchronous active-high power-on reset; clears everything |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| prewarn_irq | output | 1 | One-cycle early-warning pulse |
| wdog_rst_req | output | 1 | Held reset request after expiry |

## Verification
Each kind of wrong internal state shows up at the ports within a bounded time:
- A key sequencer stuck in the armed state lets a lone second-key write through. The control readback changes on the very next read.
- A sequencer that does not fall back to idle shows the same way after a bad key.
- A prescaler that selects the wrong ratio, or fails to restart on a load, moves the status count one decrement early or late. The bench samples the count on both sides of the expected edge.
- A wrong early-warning threshold misplaces the one-cycle pulse by at least one tick.
- A reset-cause flag tied to the warm reset reads 0 immediately after `rst`.

// File: rtl/guarded_wdog_pkg.sv
package guarded_wdog_pkg;

    localparam logic [7:0] KEY_ARM    = 8'hBE;
    localparam logic [7:0] KEY_COMMIT = 8'hDC;

    localparam int OFS_CTRL  = 'h0;
    localparam int OFS_CAUSE = 'h4;
    localparam int OFS_STAT  = 'h8;

    localparam int CNT_W = 16;

    typedef enum logic { SEQ_IDLE, SEQ_ARMED } seq_state_t;

    typedef struct packed {
        logic             en;
        logic [1:0]       warn_sel;
        logic [1:0]       div_sel;
        logic [CNT_W-1:0] reload;
    } wd_cfg_t;

    function automatic logic [7:0] key_of(input logic [31:0] w);
        return w[23:16];
    endfunction

    function automatic wd_cfg_t cfg_from_word(input logic [31:0] w);
        wd_cfg_t c;
        c.en       = w[31];
        c.warn_sel = w[27:26];
        c.div_sel  = w[25:24];
        c.reload   = w[15:0];
        return c;
    endfunction

    function automatic logic [31:0] word_from_cfg(input wd_cfg_t c);
        return {c.en, 3'b000, c.warn_sel, c.div_sel, 8'h00, c.reload};
    endfunction

    function automatic logic [CNT_W-1:0] warn_level(input logic [1:0] sel);
        return {CNT_W{1'b1}} >> (int'(sel) + 1);
    endfunction

endpackage

// File: rtl/gwd_unlock.sv
module gwd_unlock
    import guarded_wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic [7:0] key,
    output logic       commit
);
    seq_state_t state_q;

    assign commit = ctrl_wr && (state_q == SEQ_ARMED) && (key == KEY_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else if (ctrl_wr) begin
            if (state_q == SEQ_IDLE && key == KEY_ARM)
                state_q <= SEQ_ARMED;
            else
                state_q <= SEQ_IDLE;
        end
    end
endmodule

// File: rtl/gwd_prescale.sv
module gwd_prescale #(
    parameter int DIV0 = 1,
    parameter int DIV1 = 64,
    parameter int DIV2 = 4096,
    parameter int DIV3 = 262144
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int DIV_A  = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int DIV_B  = (DIV2 > DIV3) ? DIV2 : DIV3;
    localparam int DIVMAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int PCW    = (DIVMAX > 2) ? $clog2(DIVMAX) : 1;

    logic [PCW-1:0] pcnt_q;
    logic [PCW-1:0] last;

    always_comb begin
        case (sel)
            2'd0:    last = PCW'(DIV0 - 1);
            2'd1:    last = PCW'(DIV1 - 1);
            2'd2:    last = PCW'(DIV2 - 1);
            default: last = PCW'(DIV3 - 1);
        endcase
    end

    assign tick = run && (pcnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            pcnt_q <= '0;
        else if (pcnt_q == last)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/gwd_counter.sv
module gwd_counter
    import guarded_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] warn_at,
    output logic [CNT_W-1:0] count,
    output logic             warn_pulse,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            warn_pulse <= 1'b0;
            expired    <= 1'b0;
        end else begin
            warn_pulse <= 1'b0;
            if (load) begin
                cnt_q <= reload;
            end else if (run && tick && cnt_q != '0) begin
                cnt_q      <= cnt_q - 1'b1;
                warn_pulse <= ((cnt_q - 1'b1) == warn_at);
            end
            if (run && !load && cnt_q == '0)
                expired <= 1'b1;
        end
    end
endmodule

// File: rtl/guarded_wdog.sv
module guarded_wdog
    import guarded_wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DIV0   = 1,
    parameter int DIV1   = 64,
    parameter int DIV2   = 4096,
    parameter int DIV3   = 262144
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              prewarn_irq,
    output logic              wdog_rst_req
);
    logic             rst_any;
    logic             ctrl_wr;
    logic             commit;
    logic             load;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             cause_q;
    wd_cfg_t          cfg_q;

    assign rst_any = rst || por_rst;
    assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign load    = commit && bus_wdata[31];

    gwd_unlock u_unlock (
        .clk     (clk),
        .rst     (rst_any),
        .ctrl_wr (ctrl_wr),
        .key     (key_of(bus_wdata)),
        .commit  (commit)
    );

    always_ff @(posedge clk) begin
        if (rst_any)
            cfg_q <= '0;
        else if (commit)
            cfg_q <= cfg_from_word(bus_wdata);
    end

    gwd_prescale #(
        .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
    ) u_prescale (
        .clk     (clk),
        .rst     (rst_any),
        .restart (load),
        .run     (cfg_q.en),
        .sel     (cfg_q.div_sel),
        .tick    (tick)
    );

    gwd_counter u_counter (
        .clk        (clk),
        .rst        (rst_any),
        .load       (load),
        .reload     (bus_wdata[15:0]),
        .run        (cfg_q.en),
        .tick       (tick),
        .warn_at    (warn_level(cfg_q.warn_sel)),
        .count      (cnt),
        .warn_pulse (prewarn_irq),
        .expired    (wdog_rst_req)
    );

    always_ff @(posedge clk) begin
        if (por_rst)
            cause_q <= 1'b0;
        else if (wdog_rst_req)
            cause_q <= 1'b1;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_CTRL):  bus_rdata = word_from_cfg(cfg_q);
            ADDR_W'(OFS_CAUSE): bus_rdata = {cause_q, 31'd0};
            ADDR_W'(OFS_STAT):  bus_rdata = {cfg_q.en, 15'd0, cnt};
            default:            bus_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/guarded_wdog_checker.sv
module guarded_wdog_checker
    import guarded_wdog_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_any,
    input logic              por_rst,
    input logic              commit,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input wd_cfg_t           cfg_q,
    input logic [CNT_W-1:0]  cnt,
    input logic              cause_q,
    input logic              prewarn_irq,
    input logic              wdog_rst_req
);
    a_r2_cfg_guarded: assert property (@(posedge clk) disable iff (rst_any)
        !commit |=> $stable(cfg_q));

    a_r3_commit_after_arm: assert property (@(posedge clk) disable iff (rst_any)
        commit |-> $past(bus_we && bus_addr == ADDR_W'(OFS_CTRL)
                         && bus_wdata[23:16] == KEY_ARM));

    a_r4_count_only_down: assert property (@(posedge clk) disable iff (rst_any)
        !commit |=> cnt <= $past(cnt));

    a_r8_prewarn_single: assert property (@(posedge clk) disable iff (rst_any)
        prewarn_irq |=> !prewarn_irq);

    a_r9_req_held: assert property (@(posedge clk) disable iff (rst_any)
        wdog_rst_req |=> wdog_rst_req);

    a_r10_cause_follows: assert property (@(posedge clk) disable iff (por_rst)
        wdog_rst_req |=> cause_q);
endmodule

bind guarded_wdog guarded_wdog_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk          (clk),
    .rst_any      (rst_any),
    .por_rst      (por_rst),
    .commit       (commit),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .cfg_q        (cfg_q),
    .cnt          (cnt),
    .cause_q      (cause_q),
    .prewarn_irq  (prewarn_irq),
    .wdog_rst_req (wdog_rst_req)
);

// File: tb/guarded_wdog_test.sv
module guarded_wdog_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        prewarn_irq;
    logic        wdog_rst_req;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    guarded_wdog #(.ADDR_W(4), .DIV0(1), .DIV1(2), .DIV2(4), .DIV3(8)) uut (
        .clk(clk), .rst(rst), .por_rst(por_rst), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .prewarn_irq(prewarn_irq), .wdog_rst_req(wdog_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        bus_addr  = 4'h0;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic unlocked(input logic [31:0] cfg);
        wr(32'h00BE0000);
        wr(cfg | 32'h00DC0000);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'h0, d); chk("R1 ctrl", d, 0);
        rd(4'h8, d); chk("R1 status", d, 0);
        rd(4'h4, d); chk("R1 cause", d, 0);
        chk("R1 outputs", {prewarn_irq, wdog_rst_req}, 0);
    endtask

    task automatic t_unlock;
        logic [31:0] d;
        wr(32'h80DC0010);
        rd(4'h0, d); chk("R2 lone second key", d, 0);
        unlocked(32'h0B001234);
        rd(4'h0, d); chk("R11 readback", d, 32'h0B001234);
        rd(4'h8, d); chk("R7 not running", d, 0);
    endtask

    task automatic t_bad_keys;
        logic [31:0] d;
        wr(32'h00BE0000); wr(32'h00120000); wr(32'h00DC0077);
        rd(4'h0, d); chk("R3 foreign byte", d, 32'h0B001234);
        wr(32'h00BE0000); wr(32'h00BE0000); wr(32'h00DC0077);
        rd(4'h0, d); chk("R3 double arm", d, 32'h0B001234);
    endtask

    task automatic t_run_div;
        logic [31:0] d;
        unlocked(32'h80000010);
        rd(4'h8, d); chk("R4 loaded", d, 32'h80000010);
        wait_cyc(3);
        rd(4'h8, d); chk("R4 counting", d, 32'h8000000D);
        unlocked(32'h82000010);
        wait_cyc(3);
        rd(4'h8, d); chk("R5 div sel 2 before", d, 32'h80000010);
        wait_cyc(1);
        rd(4'h8, d); chk("R5 div sel 2 after", d, 32'h8000000F);
        unlocked(32'h83000010);
        wait_cyc(7);
        rd(4'h8, d); chk("R5 div sel 3 before", d, 32'h80000010);
        wait_cyc(1);
        rd(4'h8, d); chk("R5 div sel 3 after", d, 32'h8000000F);
    endtask

    task automatic t_keepalive_stop;
        logic [31:0] d, v;
        unlocked(32'h80000010);
        wait_cyc(5);
        rd(4'h8, d); chk("R6 pre-kick", d, 32'h8000000B);
        unlocked(32'h80000010);
        rd(4'h8, d); chk("R6 reloaded", d, 32'h80000010);
        unlocked(32'h00000010);
        rd(4'h8, v); chk("R7 stopped flag", v[31], 0);
        wait_cyc(20);
        rd(4'h8, d); chk("R7 frozen", d, v);
        chk("R7 no request", wdog_rst_req, 0);
    endtask

    task automatic t_prewarn;
        unlocked(32'h8C001003);
        wait_cyc(3);
        chk("R8 e3 before", prewarn_irq, 0);
        wait_cyc(1);
        chk("R8 e3 pulse", prewarn_irq, 1);
        wait_cyc(1);
        chk("R8 e3 single", prewarn_irq, 0);
        unlocked(32'h80008001);
        wait_cyc(1);
        chk("R8 e0 before", prewarn_irq, 0);
        wait_cyc(1);
        chk("R8 e0 pulse", prewarn_irq, 1);
        unlocked(32'h00000000);
    endtask

    task automatic t_expire;
        logic [31:0] d;
        unlocked(32'h8C000003);
        wait_cyc(3);
        rd(4'h8, d); chk("R9 count zero", d, 32'h80000000);
        chk("R9 not yet", wdog_rst_req, 0);
        wait_cyc(1);
        chk("R9 raised", wdog_rst_req, 1);
        wait_cyc(10);
        chk("R9 held", wdog_rst_req, 1);
        rd(4'h4, d); chk("R10 cause set", d, 32'h80000000);
        rst = 1'b1; wait_cyc(2); rst = 1'b0;
        chk("R9 cleared by rst", wdog_rst_req, 0);
        rd(4'h0, d); chk("R1 ctrl after rst", d, 0);
        rd(4'h4, d); chk("R10 survives rst", d, 32'h80000000);
        por_rst = 1'b1; wait_cyc(2); por_rst = 1'b0;
        rd(4'h4, d); chk("R10 cleared by por", d, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        por_rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_unlock();
        t_bad_keys();
        t_run_div();
        t_keepalive_stop();
        t_prewarn();
        t_expire();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule